// File: doc/BRIEF.md
# Half-Sample Bicubic Block Interpolator

This block builds the half-sample prediction for an 8x8 pixel block using two separable passes of the four-tap kernel (-1, 9, 9, -1). Reference rows arrive one per cycle. A vertical pass combines each new row with the three rows held before it. It produces one row of signed 16-bit intermediate samples, using a programmable rounding value and a programmable right shift, and it does not clip. A horizontal pass then filters that intermediate row into eight 8-bit pixels, rounds them, shifts them by seven and saturates them. In averaging mode each result is also averaged with the pixel already at the destination.

A user pulses `start` with the configuration on the `cfg_*` inputs. The user then presents 11 reference rows of 11 pixels each, covering positions -1 to +9 of the block in both directions. From the fourth reference row on, every row also carries the matching destination row. Each such row yields one output row two cycles later. A `done` pulse marks the end of the block, and the block then goes idle.

Top module: `hpel_bicubic`

## Requirements
- R1: An intermediate sample at column c for output row y is ((9*(P[y+1][c] + P[y+2][c]) - P[y][c] - P[y+3][c] + cfg_rnd_v) >>> cfg_shift), where P[k] is the k-th reference row accepted. The result keeps only its low 16 bits as a two's-complement value, with no clipping.
- R2: Output pixel x of a row is ((9*(M[x+1] + M[x+2]) - M[x] - M[x+3] + cfg_rnd_h) >>> 7), where M is that row's intermediate samples. It is computed at full precision and then saturated to 0..255.
- R3: When cfg_avg was 1 at start, each output pixel is (F + D + 1) >> 1, where F is the R2 value and D is the matching `dest_row` pixel.
- R4: Pixel i of `ref_row` sits at bits [8*i+7:8*i] and stands for horizontal position i-1. Pixel x of `dest_row` and `out_row` sits at bits [8*x+7:8*x]. Reference row k stands for vertical position k-1.
- R5: A row is accepted in any busy cycle where `ref_valid` is high, and gaps are allowed. Reference row k (k = 3..10) completes output row k-3. The `dest_row` presented with that reference row is the destination for that output row. `out_valid` rises two clock edges after the reference row is accepted.
- R6: `done` is high for exactly one cycle, the cycle after the eighth output row. `busy` is low in that same cycle.
- R7: `ref_valid` while idle has no effect, and `start` while busy has no effect.
- R8: The configuration is captured when `start` is accepted. Changes to it during a block do not affect that block.
- R9: After reset, `busy`, `out_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a block and capture the configuration |
| cfg_avg | input | 1 | 1 = average the result with the destination pixel |
| cfg_rnd_v | input | 16 | Signed rounding value for the vertical pass |
| cfg_shift | input | 4 | Right-shift amount for the vertical pass |
| cfg_rnd_h | input | 16 | Signed rounding value for the horizontal pass |
| ref_valid | input | 1 | A reference row is present |
| ref_row | input | 88 | 11 reference pixels, 8 bits each |
| dest_row | input | 64 | Destination pixels that go with the reference row |
| busy | output | 1 | A block is in progress |
| out_valid | output | 1 | `out_row` holds a new output row |
| out_row | output | 64 | 8 output pixels |
| done | output | 1 | One-cycle end-of-block pulse |

## Verification
The bench uses the default block size of 8, so a whole block takes about 15 cycles. It can therefore check every output row of every block it runs. It sweeps all shift values from 0 to 7 in both put and averaging modes. Four pixel patterns (random, all-white, a 0/255 checkerboard and a ramp) drive the intermediates negative, past 8 bits and into both saturation limits. Some blocks insert a stall row, a stray `start` and configuration changes in the middle of the block, which exercises capture and the ignore rules.

// File: rtl/hpel_pkg.sv
package hpel_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_FEED, ST_FLUSH} hpel_state_e;

  // Four-tap (-1, 9, 9, -1) kernel on wide signed operands
  function automatic logic signed [31:0] tap4(input logic signed [31:0] a,
                                              input logic signed [31:0] b,
                                              input logic signed [31:0] c,
                                              input logic signed [31:0] d);
    return 32'sd9 * (b + c) - a - d;
  endfunction

  // Vertical pass: 8-bit pixels -> wrapped signed 16-bit intermediate
  function automatic logic [15:0] vert_sample(input logic [7:0] a,
                                              input logic [7:0] b,
                                              input logic [7:0] c,
                                              input logic [7:0] d,
                                              input logic signed [15:0] rnd,
                                              input logic [3:0] sh);
    logic signed [31:0] s;
    s = tap4($signed({24'd0, a}), $signed({24'd0, b}),
             $signed({24'd0, c}), $signed({24'd0, d})) + 32'(rnd);
    s = s >>> sh;
    return s[15:0];
  endfunction

  // Horizontal pass: intermediates -> saturated 8-bit pixel
  function automatic logic [7:0] horiz_pixel(input logic signed [15:0] a,
                                             input logic signed [15:0] b,
                                             input logic signed [15:0] c,
                                             input logic signed [15:0] d,
                                             input logic signed [15:0] rnd);
    logic signed [31:0] s;
    s = tap4(32'(a), 32'(b), 32'(c), 32'(d)) + 32'(rnd);
    s = s >>> 7;
    if (s < 0) return 8'd0;
    else if (s > 255) return 8'd255;
    else return s[7:0];
  endfunction

  function automatic logic [7:0] avg_round(input logic [7:0] x, input logic [7:0] y);
    logic [8:0] t;
    t = {1'b0, x} + {1'b0, y} + 9'd1;
    return t[8:1];
  endfunction

endpackage

// File: rtl/hpel_ctrl.sv
module hpel_ctrl
  import hpel_pkg::*;
#(
  parameter int BLK = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ref_valid,
  input  logic out_valid,
  output logic busy,
  output logic load,
  output logic vfire,
  output logic done
);
  localparam int ROWS = BLK + 3;
  localparam int RCW  = $clog2(ROWS + 1);
  localparam int OCW  = $clog2(BLK + 1);

  hpel_state_e      st;
  logic [RCW-1:0]   row_cnt;
  logic [OCW-1:0]   out_cnt;
  logic             last_out;

  assign busy     = (st != ST_IDLE);
  assign load     = (st == ST_FEED) && ref_valid;
  assign vfire    = load && (row_cnt >= RCW'(3));
  assign last_out = out_valid && (out_cnt == OCW'(BLK - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      row_cnt <= '0;
      out_cnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= last_out;
      if (out_valid) out_cnt <= out_cnt + OCW'(1);
      case (st)
        ST_IDLE: if (start) begin
          st      <= ST_FEED;
          row_cnt <= '0;
          out_cnt <= '0;
        end
        ST_FEED: if (load) begin
          row_cnt <= row_cnt + RCW'(1);
          if (row_cnt == RCW'(ROWS - 1)) st <= ST_FLUSH;
        end
        default: if (last_out) st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hpel_vpass.sv
module hpel_vpass
  import hpel_pkg::*;
#(
  parameter int COLS = 11
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic                   vfire,
  input  logic [COLS*8-1:0]      ref_row,
  input  logic signed [15:0]     rnd,
  input  logic [3:0]             sh,
  output logic [COLS*16-1:0]     mid_row,
  output logic                   mid_valid
);
  logic [COLS*8-1:0]  win0, win1, win2;
  logic [COLS*16-1:0] mid_next;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign mid_next[c*16 +: 16] = vert_sample(win0[c*8 +: 8], win1[c*8 +: 8],
                                              win2[c*8 +: 8], ref_row[c*8 +: 8],
                                              rnd, sh);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win0      <= '0;
      win1      <= '0;
      win2      <= '0;
      mid_row   <= '0;
      mid_valid <= 1'b0;
    end else begin
      mid_valid <= vfire;
      if (load) begin
        win0 <= win1;
        win1 <= win2;
        win2 <= ref_row;
      end
      if (vfire) mid_row <= mid_next;
    end
  end
endmodule

// File: rtl/hpel_hpass.sv
module hpel_hpass
  import hpel_pkg::*;
#(
  parameter int BLK  = 8,
  parameter int COLS = BLK + 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mid_valid,
  input  logic [COLS*16-1:0]     mid_row,
  input  logic                   cap,
  input  logic [BLK*8-1:0]       dest_row,
  input  logic                   avg_en,
  input  logic signed [15:0]     rnd,
  output logic [BLK*8-1:0]       out_row,
  output logic                   out_valid
);
  logic [BLK*8-1:0] dest_q;
  logic [BLK*8-1:0] pix_next;

  for (genvar x = 0; x < BLK; x++) begin : g_pix
    logic [7:0] filt;
    assign filt = horiz_pixel(mid_row[x*16 +: 16], mid_row[(x+1)*16 +: 16],
                              mid_row[(x+2)*16 +: 16], mid_row[(x+3)*16 +: 16], rnd);
    assign pix_next[x*8 +: 8] = avg_en ? avg_round(filt, dest_q[x*8 +: 8]) : filt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_q    <= '0;
      out_row   <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= mid_valid;
      if (cap) dest_q <= dest_row;
      if (mid_valid) out_row <= pix_next;
    end
  end
endmodule

// File: rtl/hpel_bicubic.sv
module hpel_bicubic #(
  parameter int BLK  = 8,
  parameter int COLS = BLK + 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 cfg_avg,
  input  logic [15:0]          cfg_rnd_v,
  input  logic [3:0]           cfg_shift,
  input  logic [15:0]          cfg_rnd_h,
  input  logic                 ref_valid,
  input  logic [COLS*8-1:0]    ref_row,
  input  logic [BLK*8-1:0]     dest_row,
  output logic                 busy,
  output logic                 out_valid,
  output logic [BLK*8-1:0]     out_row,
  output logic                 done
);
  logic               load, vfire, mid_valid;
  logic [COLS*16-1:0] mid_row;
  logic               avg_q;
  logic [15:0]        rnd_v_q, rnd_h_q;
  logic [3:0]         shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avg_q   <= 1'b0;
      rnd_v_q <= '0;
      rnd_h_q <= '0;
      shift_q <= '0;
    end else if (start && !busy) begin
      avg_q   <= cfg_avg;
      rnd_v_q <= cfg_rnd_v;
      rnd_h_q <= cfg_rnd_h;
      shift_q <= cfg_shift;
    end
  end

  hpel_ctrl #(.BLK(BLK)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_valid(ref_valid),
    .out_valid(out_valid), .busy(busy), .load(load), .vfire(vfire), .done(done)
  );

  hpel_vpass #(.COLS(COLS)) vpass_i (
    .clk(clk), .rst_n(rst_n), .load(load), .vfire(vfire), .ref_row(ref_row),
    .rnd($signed(rnd_v_q)), .sh(shift_q), .mid_row(mid_row), .mid_valid(mid_valid)
  );

  hpel_hpass #(.BLK(BLK), .COLS(COLS)) hpass_i (
    .clk(clk), .rst_n(rst_n), .mid_valid(mid_valid), .mid_row(mid_row),
    .cap(vfire), .dest_row(dest_row), .avg_en(avg_q), .rnd($signed(rnd_h_q)),
    .out_row(out_row), .out_valid(out_valid)
  );
endmodule

// File: rtl/hpel_bicubic_chk.sv
module hpel_bicubic_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic out_valid,
  input logic done,
  input logic mid_valid,
  input logic vfire
);
  // R5: a finished intermediate row becomes an output row on the next edge
  a_r5_mid_to_out: assert property (@(posedge clk) disable iff (!rst_n)
    mid_valid |=> out_valid);

  // R5: a vertical result appears one edge after its row was fired
  a_r5_fire_to_mid: assert property (@(posedge clk) disable iff (!rst_n)
    vfire |=> mid_valid);

  // R6: done follows an output row and the block is already idle
  a_r6_done_after_row: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(out_valid) && !busy && !out_valid));

  // R6: done never lasts two cycles
  a_r6_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: nothing comes out when the block is idle
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !out_valid);
endmodule

bind hpel_bicubic hpel_bicubic_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .out_valid(out_valid),
  .done(done), .mid_valid(mid_valid), .vfire(vfire)
);

// File: tb/hpel_bicubic_tb_top.sv
module hpel_bicubic_tb_top;
  localparam int BLK  = 8;
  localparam int COLS = BLK + 3;
  localparam int ROWS = BLK + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, cfg_avg = 1'b0, ref_valid = 1'b0;
  logic [15:0] cfg_rnd_v = '0, cfg_rnd_h = '0;
  logic [3:0]  cfg_shift = '0;
  logic [COLS*8-1:0] ref_row = '0;
  logic [BLK*8-1:0]  dest_row = '0;
  logic busy, out_valid, done;
  logic [BLK*8-1:0] out_row;

  always #10 clk = ~clk;   // 50 MHz

  hpel_bicubic #(.BLK(BLK)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_avg(cfg_avg),
    .cfg_rnd_v(cfg_rnd_v), .cfg_shift(cfg_shift), .cfg_rnd_h(cfg_rnd_h),
    .ref_valid(ref_valid), .ref_row(ref_row), .dest_row(dest_row),
    .busy(busy), .out_valid(out_valid), .out_row(out_row), .done(done)
  );

  int checks = 0, errors = 0;
  int ref_pix [ROWS][COLS];
  int dst_pix [BLK][BLK];
  int exp_pix [BLK][BLK];
  int oidx = 0, ndone = 0, nout_total = 0;
  bit prev_ov = 0, finished = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      logic [BLK*8-1:0] e;
      nout_total++;
      for (int x = 0; x < BLK; x++) e[x*8 +: 8] = (oidx < BLK) ? 8'(exp_pix[oidx][x]) : 8'd0;
      // R1 R2 R3 R4 R5 R8: whole row against the arithmetic model
      check(oidx < BLK && out_row == e, "R1/R2/R3/R4/R5/R8 out_row", out_row, e);
      oidx++;
    end
    if (rst_n && done) begin
      ndone++;
      check(prev_ov && oidx == BLK && !busy, "R6 done timing", oidx, BLK);
    end
    prev_ov = out_valid;
  end

  function automatic int wrap16(input int v);
    int t;
    t = v & 32'hFFFF;
    return (t >= 32768) ? t - 65536 : t;
  endfunction

  task automatic run_block(input int avg, input int sh, input int rv, input int rh,
                           input int pat, input bit stall);
    int mid [BLK][COLS];
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        case (pat)
          0: ref_pix[r][c] = int'($urandom % 256);
          1: ref_pix[r][c] = 255;
          2: ref_pix[r][c] = ((r + c) % 2 == 1) ? 255 : 0;
          default: ref_pix[r][c] = (r * 23 + c * 9) % 256;
        endcase
    for (int y = 0; y < BLK; y++)
      for (int x = 0; x < BLK; x++) dst_pix[y][x] = int'($urandom % 256);
    for (int y = 0; y < BLK; y++)
      for (int c = 0; c < COLS; c++)
        mid[y][c] = wrap16((9 * ref_pix[y+1][c] + 9 * ref_pix[y+2][c]
                            - ref_pix[y][c] - ref_pix[y+3][c] + rv) >>> sh);
    for (int y = 0; y < BLK; y++)
      for (int x = 0; x < BLK; x++) begin
        int h;
        h = (9 * mid[y][x+1] + 9 * mid[y][x+2] - mid[y][x] - mid[y][x+3] + rh) >>> 7;
        if (h < 0) h = 0;
        if (h > 255) h = 255;
        if (avg != 0) h = (h + dst_pix[y][x] + 1) / 2;
        exp_pix[y][x] = h;
      end
    oidx = 0;
    ndone = 0;
    @(negedge clk);
    start = 1'b1; cfg_avg = (avg != 0); cfg_shift = 4'(sh);
    cfg_rnd_v = 16'(rv); cfg_rnd_h = 16'(rh);
    @(negedge clk);
    start = 1'b0;
    // R8: scramble configuration after capture
    cfg_avg = ~cfg_avg; cfg_shift = 4'($urandom); cfg_rnd_v = 16'($urandom);
    cfg_rnd_h = 16'($urandom);
    for (int k = 0; k < ROWS; k++) begin
      if (stall && k == 6) begin
        ref_valid = 1'b0;
        start = 1'b1;            // R7: start while busy is ignored
        ref_row = '1;
        @(negedge clk);
        start = 1'b0;
      end
      ref_valid = 1'b1;
      for (int c = 0; c < COLS; c++) ref_row[c*8 +: 8] = 8'(ref_pix[k][c]);
      for (int x = 0; x < BLK; x++)
        dest_row[x*8 +: 8] = (k >= 3) ? 8'(dst_pix[k-3][x]) : 8'($urandom);
      @(negedge clk);
    end
    ref_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(oidx == BLK, "R5 rows per block", oidx, BLK);
    check(ndone == 1 && !busy, "R6 single done and idle", ndone, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !out_valid && !done, "R9 reset state", {busy, out_valid, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !out_valid && !done, "R9 after reset release", {busy, out_valid, done}, 0);
    // R7: rows offered while idle are ignored
    for (int i = 0; i < 6; i++) begin
      ref_valid = 1'b1;
      ref_row = {COLS{8'hA5}};
      @(negedge clk);
    end
    ref_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(nout_total == 0 && !busy, "R7 idle rows ignored", nout_total, 0);
    for (int sh = 0; sh < 8; sh++)
      for (int avg = 0; avg < 2; avg++)
        for (int pat = 0; pat < 4; pat++)
          run_block(avg, sh, (pat == 2) ? -(sh * 3) : ((1 << sh) >>> 1),
                    (pat == 3) ? -40 : 64 - sh, pat, (pat + sh) % 2 == 1);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule